// File: doc/BRIEF.md
# Serial Real-Time-Clock Register Slave

This block is the device end of a three-wire serial link to a real-time-clock register file. The host raises chip enable, clocks in a command byte and then moves one or more data bytes, least-significant bit first. The command byte chooses between reading and writing, between the clock space and a scratch RAM space, and a five-bit register address. The clock space holds seven packed-BCD time and date registers, a control register whose top bit is a write lock, and an eight-bit charge-setting register. One reserved address streams the clock registers in sequence, so the host can move the whole time in a single transaction.

The time registers are plain storage. They do not count. A local host port can load and read them directly, with no regard to the write lock. The serial inputs are brought into the system clock domain by a synchronizer and then edge-detected, so the system clock must run well above the serial clock.

Top module: `rtc_ser_slave`

## Requirements
- R1: After reset, time registers 0 to 6 read 0x00 on the host port. The control register reads 0x80 (locked) and `sdo` is 0.
- R2: A command byte is accepted only when bit 7 is 1. Bit 0 set means read, clear means write. Bits 5:1 carry the address and bit 6 set selects RAM. A command with bit 7 clear makes the rest of the transaction change nothing and keeps `sdo` at 0.
- R3: On a single write, the data byte is sampled on rising `sclk`, LSB first, and stored at the addressed location. Clock addresses are 0x00 to 0x06 time, 0x07 control and 0x08 charge setting. Further bytes in the same single transaction are ignored.
- R4: On a single read, bit 0 of the addressed register appears on `sdo` at the falling `sclk` edge after the eighth command bit. The next seven bits follow on the next seven falling edges, LSB first. From the following falling edge `sdo` is 0.
- R5: While control bit 7 is 1, serial writes to every location except control are dropped. A serial write to control is always accepted and sets the lock to data bit 7. Control bits 6:0 always read 0.
- R6: Clock address 0x1F with bit 6 clear is burst mode. Bytes go to or come from registers 0x00, 0x01 and so on up to 0x07 (control) in that order, then wrap to 0x00. This holds for both read (command 0xBF) and write (command 0xBE).
- R7: RAM location n is at command address n with bit 6 set, for n from 0 to RAM_DEPTH-1. Address 0x1F with bit 6 set bursts through RAM from 0 and wraps to 0 after RAM_DEPTH-1.
- R8: Clock addresses 0x09 to 0x1E read 0x00, and writes to them change nothing.
- R9: Dropping `ce` aborts the transaction. A partly shifted byte is discarded, and the next transaction starts again with a command byte.
- R10: A host write to address 0 to 6 loads that time register, and a host write to 7 sets the lock from data bit 7. The write lock has no effect on host writes. `host_rdata` shows the register at `host_addr` in the same cycle.
- R11: `sdo` is 0 whenever the block is not shifting out read data: during write transactions and while `ce` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Serial chip enable, active high |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| host_we | input | 1 | Local port write strobe |
| host_addr | input | 3 | Local port address (0-6 time, 7 control) |
| host_wdata | input | 8 | Local port write data |
| host_rdata | output | 8 | Local port read data |

## Verification
The properties assume that `ce`, `sclk` and `sdi` each stay stable for several system clocks around every change. Each serial edge must then show up as exactly one synchronized rise or fall, and a write strobe cannot follow a dropped enable. They also assume that host port writes never land in the same cycle as a serial write strobe. The stimulus changes serial inputs only on falling system clock edges, holds every serial level for 50 system clocks, and issues host writes only while no serial transaction is active.

// File: rtl/rtc_ser_pkg.sv
// Shared constants and types for the serial RTC register slave.
// Assumes a five-bit register address space per register bank.
package rtc_ser_pkg;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] BURST_ADDR   = 5'h1F;
    localparam logic [ADDR_W-1:0] CTRL_ADDR    = 5'h07;
    localparam logic [ADDR_W-1:0] TRICKLE_ADDR = 5'h08;
    localparam int NUM_TIME = 7;

    typedef enum logic [1:0] {
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_DONE
    } xfer_st_t;
endpackage

// File: rtl/rtc_ser_sync.sv
// Multi-bit synchronizer chain for slow asynchronous serial inputs.
// Assumes each input bit changes far less often than clk toggles.
module rtc_ser_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // First stage captures the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        // Each further stage re-registers the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[k] <= '0;
            else        pipe[k] <= pipe[k-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rtc_ser_engine.sv
// Serial protocol engine: decodes the command byte, shifts data in on
// rising sclk and out on falling sclk, LSB first, steps burst addresses.
// Assumes ce_s/sdi_s are synchronized and rise/fall are one-cycle pulses.
module rtc_ser_engine
    import rtc_ser_pkg::*;
#(
    parameter int RAM_DEPTH = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              sdi_s,
    input  logic              rise,
    input  logic              fall,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ram,
    output logic              burst,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_ram,
    output logic [7:0]        wr_data,
    output logic              sdo
);
    localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_DEPTH - 1);

    xfer_st_t          st;
    logic [2:0]        bcnt, ocnt;
    logic [6:0]        sh, tx;
    logic [ADDR_W-1:0] a_q;
    logic              ram_q, burst_q, sdo_q;
    logic [7:0]        byte_in;
    logic [ADDR_W-1:0] nxt;

    assign byte_in = {sdi_s, sh};

    // Next burst address with wrap inside the selected space.
    always_comb begin
        if (ram_q) nxt = (a_q == RAM_LAST)  ? '0 : a_q + 1'b1;
        else       nxt = (a_q == CTRL_ADDR) ? '0 : a_q + 1'b1;
    end

    // Transaction state, shift registers and output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_CMD; bcnt <= '0; ocnt <= '0; sh <= '0; tx <= '0;
            a_q <= '0; ram_q <= 1'b0; burst_q <= 1'b0; sdo_q <= 1'b0;
            wr_stb <= 1'b0; wr_addr <= '0; wr_ram <= 1'b0; wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (!ce_s) begin
                st <= ST_CMD; bcnt <= '0; ocnt <= '0; sdo_q <= 1'b0;
            end else begin
                if (rise && (st == ST_CMD || st == ST_WR)) begin
                    sh   <= byte_in[7:1];
                    bcnt <= bcnt + 3'd1;
                    if (bcnt == 3'd7) begin
                        if (st == ST_CMD) begin
                            if (!byte_in[7]) begin
                                st <= ST_DONE;
                            end else begin
                                ram_q   <= byte_in[6];
                                burst_q <= (byte_in[5:1] == BURST_ADDR);
                                a_q     <= (byte_in[5:1] == BURST_ADDR) ? '0 : byte_in[5:1];
                                st      <= byte_in[0] ? ST_RD : ST_WR;
                                ocnt    <= '0;
                            end
                        end else begin
                            wr_stb  <= 1'b1;
                            wr_addr <= a_q;
                            wr_ram  <= ram_q;
                            wr_data <= byte_in;
                            if (burst_q) a_q <= nxt;
                            else         st  <= ST_DONE;
                        end
                    end
                end
                if (fall) begin
                    if (st == ST_RD) begin
                        if (ocnt == 3'd0) begin
                            sdo_q <= rd_data[0];
                            tx    <= rd_data[7:1];
                        end else begin
                            sdo_q <= tx[0];
                            tx    <= {1'b0, tx[6:1]};
                        end
                        ocnt <= ocnt + 3'd1;
                        if (ocnt == 3'd7) begin
                            if (burst_q) a_q <= nxt;
                            else         st  <= ST_DONE;
                        end
                    end else begin
                        sdo_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign rd_addr = a_q;
    assign rd_ram  = ram_q;
    assign burst   = burst_q;
    assign sdo     = sdo_q;
endmodule

// File: rtl/rtc_ser_regs.sv
// Register file: seven time registers, write lock, charge setting, scratch RAM.
// Serial writes honour the lock except for control; host writes bypass it.
// Assumes host writes never coincide with a serial write strobe.
module rtc_ser_regs
    import rtc_ser_pkg::*;
#(
    parameter int RAM_DEPTH = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_ram,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ram,
    output logic [7:0]        rd_data,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              wp
);
    localparam logic [ADDR_W-1:0] RAM_LIM  = ADDR_W'(RAM_DEPTH);
    localparam logic [ADDR_W-1:0] TIME_LIM = ADDR_W'(NUM_TIME);

    logic [7:0] tm  [NUM_TIME];
    logic [7:0] ram [RAM_DEPTH];
    logic [7:0] tc;
    logic       wp_q;
    logic       ser_ok;

    assign ser_ok = wr_stb && (!wp_q || (!wr_ram && wr_addr == CTRL_ADDR));

    // Storage update: serial writes first, host port last so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TIME; i++)  tm[i]  <= '0;
            for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
            tc   <= '0;
            wp_q <= 1'b1;
        end else begin
            if (ser_ok) begin
                if (wr_ram) begin
                    if (wr_addr < RAM_LIM) ram[wr_addr] <= wr_data;
                end else if (wr_addr < TIME_LIM) begin
                    tm[wr_addr[2:0]] <= wr_data;
                end else if (wr_addr == CTRL_ADDR) begin
                    wp_q <= wr_data[7];
                end else if (wr_addr == TRICKLE_ADDR) begin
                    tc <= wr_data;
                end
            end
            if (host_we) begin
                if (host_addr == 3'd7) wp_q <= host_wdata[7];
                else                   tm[host_addr] <= host_wdata;
            end
        end
    end

    // Serial read mux over both spaces; holes read as zero.
    always_comb begin
        rd_data = '0;
        if (rd_ram) begin
            if (rd_addr < RAM_LIM) rd_data = ram[rd_addr];
        end else if (rd_addr < TIME_LIM) begin
            rd_data = tm[rd_addr[2:0]];
        end else if (rd_addr == CTRL_ADDR) begin
            rd_data = {wp_q, 7'b0};
        end else if (rd_addr == TRICKLE_ADDR) begin
            rd_data = tc;
        end
    end

    // Host read mux over the clock registers.
    always_comb begin
        if (host_addr == 3'd7) host_rdata = {wp_q, 7'b0};
        else                   host_rdata = tm[host_addr];
    end

    assign wp = wp_q;
endmodule

// File: rtl/rtc_ser_slave.sv
// Top of the serial RTC register slave: synchronizes the serial pins,
// detects sclk edges and joins the protocol engine to the register file.
// Assumes clk is at least ~20x faster than sclk.
module rtc_ser_slave
    import rtc_ser_pkg::*;
#(
    parameter int RAM_DEPTH   = 31,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic       sclk,
    input  logic       sdi,
    output logic       sdo,
    input  logic       host_we,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata
);
    logic [2:0]        pins_s;
    logic              ce_s, sclk_s, sdi_s, sclk_d, rise, fall;
    logic [7:0]        rd_data, wr_data;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic              rd_ram, wr_ram, wr_stb, burst, wp;

    rtc_ser_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ce, sclk, sdi}), .q(pins_s)
    );
    assign {ce_s, sclk_s, sdi_s} = pins_s;

    // Delayed copy of synchronized sclk for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end
    assign rise = sclk_s & ~sclk_d;
    assign fall = ~sclk_s & sclk_d;

    rtc_ser_engine #(.RAM_DEPTH(RAM_DEPTH)) u_eng (
        .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .sdi_s(sdi_s),
        .rise(rise), .fall(fall), .rd_data(rd_data),
        .rd_addr(rd_addr), .rd_ram(rd_ram), .burst(burst),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_ram(wr_ram),
        .wr_data(wr_data), .sdo(sdo)
    );

    rtc_ser_regs #(.RAM_DEPTH(RAM_DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_ram(wr_ram), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_ram(rd_ram), .rd_data(rd_data), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .wp(wp)
    );
endmodule

// File: rtl/rtc_ser_chk.sv
// Protocol checker for rtc_ser_slave, attached by bind below.
module rtc_ser_chk #(
    parameter int RAM_DEPTH = 31
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_s,
    input logic       sdo,
    input logic       wr_stb,
    input logic       wp,
    input logic [2:0] host_addr,
    input logic [7:0] host_rdata,
    input logic [4:0] a_q,
    input logic       ram_q,
    input logic       burst_q
);
    localparam logic [4:0] RAM_LAST = 5'(RAM_DEPTH - 1);

    // R5
    ctrl_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr == 3'd7 |-> host_rdata == {wp, 7'b0});

    // R11
    idle_sdo_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> !sdo);

    // R3
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R9
    wr_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(ce_s));

    // R6
    clk_burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_q && $past(burst_q) && !ram_q && !$past(ram_q)
         && $past(a_q) == 5'd7 && a_q != 5'd7) |-> a_q == 5'd0);

    // R7
    ram_burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_q && $past(burst_q) && ram_q && $past(ram_q)
         && $past(a_q) == RAM_LAST && a_q != RAM_LAST) |-> a_q == 5'd0);
endmodule

bind rtc_ser_slave rtc_ser_chk #(.RAM_DEPTH(RAM_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .sdo(sdo), .wr_stb(wr_stb),
    .wp(wp), .host_addr(host_addr), .host_rdata(host_rdata),
    .a_q(rd_addr), .ram_q(rd_ram), .burst_q(burst)
);

// File: tb/tb_rtc_ser_slave.sv
`timescale 1ns/100ps
module tb_rtc_ser_slave;
    localparam int HALF = 250;   // 2 MHz serial clock
    localparam int NV   = 18;

    logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic host_we = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic sdo;
    logic [7:0] host_rdata;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rtc_ser_slave dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdi(sdi), .sdo(sdo),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    // {is_read, req, cmd, wdata, expected}
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 4'd5,  8'h8E, 8'h00, 8'h00},  // unlock
        {1'b0, 4'd3,  8'h80, 8'h45, 8'h00},  // seconds
        {1'b1, 4'd4,  8'h81, 8'h00, 8'h45},
        {1'b0, 4'd3,  8'h82, 8'h59, 8'h00},  // minutes
        {1'b1, 4'd4,  8'h83, 8'h00, 8'h59},
        {1'b0, 4'd3,  8'h90, 8'h33, 8'h00},  // charge setting 0x08
        {1'b1, 4'd3,  8'h91, 8'h00, 8'h33},
        {1'b0, 4'd7,  8'hC0, 8'hA5, 8'h00},  // RAM 0
        {1'b1, 4'd7,  8'hC1, 8'h00, 8'hA5},
        {1'b0, 4'd7,  8'hFC, 8'h3C, 8'h00},  // RAM 30
        {1'b1, 4'd7,  8'hFD, 8'h00, 8'h3C},
        {1'b1, 4'd5,  8'h8F, 8'h00, 8'h00},  // unlocked control
        {1'b0, 4'd5,  8'h8E, 8'hFF, 8'h00},  // lock, low bits dropped
        {1'b1, 4'd5,  8'h8F, 8'h00, 8'h80},
        {1'b0, 4'd5,  8'h80, 8'h11, 8'h00},  // blocked
        {1'b1, 4'd5,  8'h81, 8'h00, 8'h45},
        {1'b0, 4'd5,  8'h90, 8'h00, 8'h00},  // blocked
        {1'b1, 4'd5,  8'h91, 8'h00, 8'h33}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic sbyte(input logic [7:0] o, output logic [7:0] r);
        for (int i = 0; i < 8; i++) begin
            sdi = o[i];
            #(HALF);
            r[i] = sdo;
            sclk = 1'b1;
            #(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic sbits(input logic [7:0] o, input int n);
        for (int i = 0; i < n; i++) begin
            sdi = o[i];
            #(HALF); sclk = 1'b1; #(HALF); sclk = 1'b0;
        end
    endtask

    task automatic ce_up;
        ce = 1'b1; #(HALF);
    endtask

    task automatic ce_down;
        #(HALF); ce = 1'b0; #(2*HALF);
    endtask

    task automatic txn_write(input logic [7:0] cmd, input logic [7:0] d);
        logic [7:0] r;
        ce_up; sbyte(cmd, r); sbyte(d, r); ce_down;
    endtask

    task automatic txn_read(input logic [7:0] cmd, output logic [7:0] r);
        logic [7:0] dummy;
        ce_up; sbyte(cmd, dummy); sbyte(8'h00, r); ce_down;
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
        host_addr = a; #1; d = host_rdata;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(900000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary;
            $finish;
        end
    end

    initial begin
        logic [7:0] r, r2;
        logic [7:0] pre [7];
        pre = '{8'h30, 8'h15, 8'h12, 8'h28, 8'h02, 8'h03, 8'h24};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            host_rd(3'(a), r); check("R1 time reg after reset", r, 8'h00);
        end
        host_rd(3'd7, r); check("R1 control after reset", r, 8'h80);
        check("R1 sdo after reset", {7'b0, sdo}, 8'h00);

        // R10: host preload ignores lock
        for (int a = 0; a < 7; a++) host_wr(3'(a), pre[a]);
        for (int a = 0; a < 7; a++) begin
            host_rd(3'(a), r); check("R10 host readback", r, pre[a]);
        end

        // R6: burst read order with wrap
        ce_up; sbyte(8'hBF, r);
        for (int i = 0; i < 9; i++) begin
            sbyte(8'h00, r);
            if (i < 7)       check("R6 burst read time", r, pre[i]);
            else if (i == 7) check("R6 burst read control", r, 8'h80);
            else             check("R6 burst read wrap", r, pre[0]);
        end
        ce_down;

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][28]) begin
                txn_read(VEC[v][23:16], r);
                n_chk++;
                if (r !== VEC[v][7:0]) begin
                    n_bad++;
                    $display("FAIL R%0d vector %0d: actual %02h expected %02h",
                             VEC[v][27:24], v, r, VEC[v][7:0]);
                end
            end else begin
                txn_write(VEC[v][23:16], VEC[v][15:8]);
            end
        end

        // R5: locked burst write changes only control
        ce_up; sbyte(8'hBE, r);
        for (int i = 0; i < 7; i++) sbyte(8'h99, r);
        sbyte(8'h80, r); ce_down;
        host_rd(3'd0, r); check("R5 locked burst sec", r, 8'h45);
        host_rd(3'd1, r); check("R5 locked burst min", r, 8'h59);
        host_rd(3'd2, r); check("R5 locked burst hour", r, 8'h12);

        // R6: unlocked burst write, ending with relock
        txn_write(8'h8E, 8'h00);
        ce_up; sbyte(8'hBE, r);
        for (int i = 0; i < 7; i++) sbyte(8'(i + 1), r);
        sbyte(8'h80, r); ce_down;
        for (int a = 0; a < 7; a++) begin
            host_rd(3'(a), r); check("R6 burst write order", r, 8'(a + 1));
        end
        host_rd(3'd7, r); check("R6 burst write control", r, 8'h80);

        // R9: abort mid-byte discards the partial write
        txn_write(8'h8E, 8'h00);
        ce_up; sbyte(8'h80, r); sbits(8'h7F, 5); ce_down;
        host_rd(3'd0, r); check("R9 aborted write", r, 8'h01);
        txn_write(8'h80, 8'h42);
        host_rd(3'd0, r); check("R9 restart after abort", r, 8'h42);

        // R2: command without bit 7 does nothing
        txn_write(8'h00, 8'h55);
        host_rd(3'd0, r); check("R2 invalid write", r, 8'h42);
        txn_read(8'h01, r); check("R2 invalid read sdo", r, 8'h00);

        // R3 / R11: extra bytes ignored, sdo low during write
        ce_up; sbyte(8'h82, r); sbyte(8'h21, r);
        check("R11 sdo during write", r, 8'h00);
        sbyte(8'h99, r); ce_down;
        host_rd(3'd1, r); check("R3 extra byte ignored", r, 8'h21);

        // R4: single read then sdo low
        host_wr(3'd0, 8'hFF);
        ce_up; sbyte(8'h81, r); sbyte(8'h00, r); sbyte(8'h00, r2); ce_down;
        check("R4 single read data", r, 8'hFF);
        check("R4 sdo low after byte", r2, 8'h00);
        check("R11 sdo with ce low", {7'b0, sdo}, 8'h00);

        // R8: holes in clock space
        txn_write(8'h94, 8'h12);
        txn_read(8'h95, r); check("R8 hole reads zero", r, 8'h00);
        txn_read(8'h91, r); check("R8 charge setting intact", r, 8'h33);

        // R7: RAM burst write with wrap, then burst read
        ce_up; sbyte(8'hFE, r);
        for (int i = 0; i < 32; i++) sbyte(8'(8'h40 + i), r);
        ce_down;
        txn_read(8'hC1, r); check("R7 RAM0 after wrap", r, 8'h5F);
        txn_read(8'hCB, r); check("R7 RAM5", r, 8'h45);
        ce_up; sbyte(8'hFF, r);
        for (int i = 0; i < 32; i++) begin
            sbyte(8'h00, r);
            check("R7 RAM burst read", r,
                  (i == 0 || i == 31) ? 8'h5F : 8'(8'h40 + i));
        end
        ce_down;

        finished = 1;
        summary;
        $finish;
    end
endmodule